// File: doc/BRIEF.md
# Address-Filtering Serial Receiver

This block receives asynchronous serial frames in which every data byte is followed by one extra flag bit that says whether the byte is a station address (flag 1) or ordinary data (flag 0). Software uses the flag to share one serial line among several stations. While the address-wait control bit is set, the receiver drops every data frame quietly. It raises no flag and no interrupt for them, and it captures only address frames, so software can compare the byte against its own station number. Capturing an address frame clears address-wait in hardware, so the data frames that follow are received normally until software sets the bit again.

The line is oversampled and each bit is decided by a majority vote of three samples taken at the bit centre. A start bit that does not hold until the centre is rejected. The receiver checks the stop bit and detects overruns. After either error it stops taking frames until software clears both error flags. A status bit shows the current level of the line, so software can tell a break from a single bad stop bit. Software reaches the block through a small register bus with control, status and data registers. A level interrupt tells software that a byte is waiting.

Top module: `mp_uart_rx`

## Requirements
- R1: A frame is one low start bit, 8 data bits sent least significant bit first, one flag bit and one high stop bit, each lasting OVS oversample ticks. Each bit is the majority of the samples at ticks OVS/2-1, OVS/2 and OVS/2+1 of the bit. A start bit that votes high is discarded as a glitch, and the receiver returns to hunting.
- R2: With address-wait (control bit 1) clear, every frame is stored whatever its flag. The flag of the last stored frame reads back in status bit 4.
- R3: With address-wait set, a frame whose flag is 0 changes neither the data register nor any status bit, and it raises no interrupt.
- R4: Storing a frame puts its byte in the data register (address 2) and sets the full flag (status bit 0). When interrupts are enabled (control bit 2), the interrupt output rises in the same cycle as the full flag.
- R5: Storing a frame with flag 1 while address-wait is set clears address-wait, so later frames with flag 0 are stored.
- R6: A read of the data register clears the full flag.
- R7: A frame that completes while the full flag is 1 sets the overrun flag (status bit 1). The new byte is dropped and the old byte is kept.
- R8: A stop bit that votes low sets the framing flag (status bit 2), and the byte is still stored.
- R9: While the overrun or framing flag is 1, no frame is stored. Writing 1 to a status bit position 1 or 2 clears that flag.
- R10: Status bit 3 reads the current synchronised level of the serial line.
- R11: The receive-enable bit (control bit 0) gates reception. Clearing it aborts a frame in progress, and nothing from that frame is stored.
- R12: After reset the control, status and data registers read 0 (status bit 3 follows the idle-high line), the interrupt is low, and a read returns its data on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Receive interrupt, high while a byte waits and interrupts are enabled |

## Verification
The assertions assume that software never writes the control register in the same cycle as a frame completes. They also assume that a read of the data register does not coincide with a completing frame, because hardware and software priorities would then overlap. The bench drives all bus traffic only after the line has been idle for more than one bit time past the stop bit, so register accesses never meet a frame completion. The serial line changes only on bit boundaries, except in the glitch and abort tests, and there it is driven well away from any completion.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] REG_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] REG_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] REG_DATA = 2'd2;

  localparam int CTL_EN   = 0;
  localparam int CTL_AW   = 1;
  localparam int CTL_IRQE = 2;

  localparam int STS_FULL = 0;
  localparam int STS_OVR  = 1;
  localparam int STS_FRM  = 2;
  localparam int STS_LINE = 3;
  localparam int STS_FLAG = 4;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              flag;
    logic              stop_ok;
  } rx_frame_t;

  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction
endpackage

// File: rtl/mpu_rx_sampler.sv
module mpu_rx_sampler #(
  parameter int CLK_DIV = 4,
  parameter int SYNC_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_i,
  output logic rx_s,
  output logic tick
);
  logic [SYNC_N-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_N-2:0], rx_i};
  end
  assign rx_s = sync_q[SYNC_N-1];

  generate
    if (CLK_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else if (cnt_q == CW'(CLK_DIV - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick = (cnt_q == CW'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/mpu_rx_deframer.sv
module mpu_rx_deframer
  import mpu_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  logic      rx_s,
  output logic      done_o,
  output rx_frame_t frame_o
);
  localparam int NBITS    = DATA_W + 3;
  localparam int IDX_W    = $clog2(NBITS);
  localparam int PH_W     = $clog2(OVS);
  localparam int MID      = OVS / 2;
  localparam int LAST_IDX = NBITS - 1;

  typedef enum logic {ST_HUNT, ST_RUN} st_e;

  st_e              st_q;
  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       votes_q;
  logic [DATA_W:0]  sh_q;
  logic             done_q;
  rx_frame_t        frm_q;
  logic             bit_v;
  logic             in_win;

  assign bit_v  = vote3(votes_q);
  assign in_win = (ph_q >= PH_W'(MID - 1)) && (ph_q <= PH_W'(MID + 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st_q    <= ST_HUNT;
      ph_q    <= '0;
      idx_q   <= '0;
      votes_q <= 3'b111;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (tick) begin
        case (st_q)
          ST_HUNT: begin
            if (!rx_s) begin
              st_q  <= ST_RUN;
              ph_q  <= PH_W'(1);
              idx_q <= '0;
            end
          end
          default: begin
            if (in_win) votes_q <= {votes_q[1:0], rx_s};
            if (ph_q == PH_W'(OVS - 1)) begin
              ph_q <= '0;
              if (idx_q == '0) begin
                if (bit_v) st_q <= ST_HUNT;
                else       idx_q <= IDX_W'(1);
              end else if (idx_q == IDX_W'(LAST_IDX)) begin
                done_q <= 1'b1;
                st_q   <= ST_HUNT;
                idx_q  <= '0;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              ph_q <= ph_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      frm_q <= '0;
    end else if (en && tick && st_q == ST_RUN && ph_q == PH_W'(OVS - 1)) begin
      if (idx_q == IDX_W'(LAST_IDX)) begin
        frm_q.data    <= sh_q[DATA_W-1:0];
        frm_q.flag    <= sh_q[DATA_W];
        frm_q.stop_ok <= bit_v;
      end else if (idx_q != '0) begin
        sh_q <= {bit_v, sh_q[DATA_W:1]};
      end
    end
  end

  assign done_o  = done_q;
  assign frame_o = frm_q;

  assert_abort_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> (st_q == ST_HUNT && !done_q));
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
    idx_q <= IDX_W'(LAST_IDX));
endmodule

// File: rtl/mpu_rx_regs.sv
module mpu_rx_regs
  import mpu_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  input  logic              done_i,
  input  rx_frame_t         frame_i,
  input  logic              line_i,
  output logic              rx_run_o
);
  logic en_q, aw_q, irqe_q;
  logic full_q, ovr_q, frm_q, flag_q, irq_q;
  logic [DATA_W-1:0] data_q, rdata_q;

  logic ctrl_wr, stat_wr, data_rd, halt, accept, store, over;
  logic en_n, aw_n, irqe_n, full_n, ovr_n, frm_n, flag_n;
  logic [DATA_W-1:0] data_n, rd_mux;

  assign ctrl_wr = bus_sel && bus_wr && bus_addr == REG_CTRL;
  assign stat_wr = bus_sel && bus_wr && bus_addr == REG_STAT;
  assign data_rd = bus_sel && bus_rd && bus_addr == REG_DATA;
  assign halt    = ovr_q || frm_q;
  assign accept  = done_i && en_q && !halt && !(aw_q && !frame_i.flag);
  assign store   = accept && !full_q;
  assign over    = accept && full_q;

  always_comb begin
    en_n   = ctrl_wr ? bus_wdata[CTL_EN]   : en_q;
    irqe_n = ctrl_wr ? bus_wdata[CTL_IRQE] : irqe_q;
    if (ctrl_wr)                         aw_n = bus_wdata[CTL_AW];
    else if (store && frame_i.flag)      aw_n = 1'b0;
    else                                 aw_n = aw_q;
    full_n = store ? 1'b1 : (data_rd ? 1'b0 : full_q);
    ovr_n  = over || (ovr_q && !(stat_wr && bus_wdata[STS_OVR]));
    frm_n  = (store && !frame_i.stop_ok) || (frm_q && !(stat_wr && bus_wdata[STS_FRM]));
    data_n = store ? frame_i.data : data_q;
    flag_n = store ? frame_i.flag : flag_q;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CTRL: begin
        rd_mux[CTL_EN]   = en_q;
        rd_mux[CTL_AW]   = aw_q;
        rd_mux[CTL_IRQE] = irqe_q;
      end
      REG_STAT: begin
        rd_mux[STS_FULL] = full_q;
        rd_mux[STS_OVR]  = ovr_q;
        rd_mux[STS_FRM]  = frm_q;
        rd_mux[STS_LINE] = line_i;
        rd_mux[STS_FLAG] = flag_q;
      end
      REG_DATA: rd_mux = data_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; aw_q <= 1'b0; irqe_q <= 1'b0;
      full_q <= 1'b0; ovr_q <= 1'b0; frm_q <= 1'b0; flag_q <= 1'b0;
      data_q <= '0; rdata_q <= '0; irq_q <= 1'b0;
    end else begin
      en_q <= en_n; aw_q <= aw_n; irqe_q <= irqe_n;
      full_q <= full_n; ovr_q <= ovr_n; frm_q <= frm_n; flag_q <= flag_n;
      data_q <= data_n;
      irq_q  <= irqe_n && full_n;
      rdata_q <= (bus_sel && bus_rd) ? rd_mux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
  assign rx_run_o  = en_q && !halt;

  assert_irq_with_full_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(full_q) && irqe_q) |-> irq_q);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !done_i) |=> !full_q);
  assert_halt_keeps_data_R9: assert property (@(posedge clk) disable iff (rst)
    (ovr_q || frm_q) |=> $stable(data_q));
  assert_discard_R3: assert property (@(posedge clk) disable iff (rst)
    (done_i && aw_q && !frame_i.flag) |=> ($stable(data_q) && $stable(flag_q)));
  assert_overrun_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (done_i && en_q && !halt && full_q && !(aw_q && !frame_i.flag)) |=> (ovr_q && $stable(data_q)));
  assert_addr_clears_aw_R5: assert property (@(posedge clk) disable iff (rst)
    (done_i && en_q && !halt && !full_q && aw_q && frame_i.flag && !ctrl_wr) |=> !aw_q);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpu_rx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OVS     = 16,
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_i,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_o
);
  logic      rx_s, tick, done, rx_run;
  rx_frame_t frame;

  mpu_rx_sampler #(.CLK_DIV(CLK_DIV), .SYNC_N(SYNC_N)) sampler_i (
    .clk(clk), .rst(rst), .rx_i(rx_i), .rx_s(rx_s), .tick(tick));

  mpu_rx_deframer #(.OVS(OVS)) deframer_i (
    .clk(clk), .rst(rst), .en(rx_run), .tick(tick), .rx_s(rx_s),
    .done_o(done), .frame_o(frame));

  mpu_rx_regs regs_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .done_i(done), .frame_i(frame), .line_i(rx_s), .rx_run_o(rx_run));
endmodule

// File: tb/mp_uart_rx_tb_top.sv
module mp_uart_rx_tb_top;
  localparam int OVS = 16;
  localparam int BIT_CLK = OVS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx = 1'b1;
  logic sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int n_checks = 0;
  int n_errs = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  mp_uart_rx #(.CLK_DIV(1), .OVS(OVS), .SYNC_N(2)) dut_i (
    .clk(clk), .rst(rst), .rx_i(rx), .bus_sel(sel), .bus_wr(wr), .bus_rd(rd),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; rd = 1; addr = a;
    @(negedge clk); sel = 0; rd = 0; d = rdata;
  endtask

  task automatic send(input logic [7:0] b, input logic flag, input logic stop, input bit keep_low);
    logic [10:0] bits;
    bits = {stop, flag, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); rx = bits[i];
      repeat (BIT_CLK - 1) @(negedge clk);
    end
    @(negedge clk); rx = keep_low ? 1'b0 : 1'b1;
    repeat (24) @(negedge clk);
  endtask

  function automatic int stat_of(bit full, bit ovr, bit frm, bit line, bit flag);
    return full + 2 * ovr + 4 * frm + 8 * line + 16 * flag;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done_run) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    bus_read(2'd0, v); chk("R12 ctrl", v, 0);
    bus_read(2'd1, v); chk("R12 status", v, stat_of(0, 0, 0, 1, 0));
    bus_read(2'd2, v); chk("R12 data", v, 0);
    chk("R12 irq", irq, 0);

    // R1 R2 R4 R6: sweep all bytes, flag alternating
    bus_write(2'd0, 8'h05);
    for (int b = 0; b < 256; b++) begin
      logic f;
      f = b[0] ^ b[3];
      send(8'(b), f, 1'b1, 0);
      chk("R4 irq", irq, 1);
      bus_read(2'd1, v); chk("R2 status", v, stat_of(1, 0, 0, 1, f));
      bus_read(2'd2, v); chk("R1 data", v, b);
      bus_read(2'd1, v); chk("R6 full cleared", v & 1, 0);
      chk("R6 irq low", irq, 0);
    end

    // R3: address-wait discards flag-0 frames
    bus_write(2'd0, 8'h07);
    for (int b = 0; b < 16; b++) begin
      send(8'(b * 17 + 3), 1'b0, 1'b1, 0);
      chk("R3 irq", irq, 0);
      bus_read(2'd1, v); chk("R3 status", v, stat_of(0, 0, 0, 1, 0));
    end
    bus_read(2'd2, v); chk("R3 data unchanged", v, 255);

    // R5: address frame accepted and clears address-wait
    send(8'h42, 1'b1, 1'b1, 0);
    chk("R4 irq addr", irq, 1);
    bus_read(2'd0, v); chk("R5 aw cleared", v, 8'h05);
    bus_read(2'd2, v); chk("R5 addr byte", v, 8'h42);
    send(8'h9C, 1'b0, 1'b1, 0);
    bus_read(2'd2, v); chk("R5 data after addr", v, 8'h9C);

    // R7 overrun then R9 halt
    send(8'h11, 1'b0, 1'b1, 0);
    send(8'h22, 1'b0, 1'b1, 0);
    bus_read(2'd1, v); chk("R7 status", v, stat_of(1, 1, 0, 1, 0));
    bus_read(2'd2, v); chk("R7 old kept", v, 8'h11);
    send(8'h33, 1'b0, 1'b1, 0);
    bus_read(2'd1, v); chk("R9 halted ovr", v, stat_of(0, 1, 0, 1, 0));
    bus_write(2'd1, 8'h02);
    bus_read(2'd1, v); chk("R9 ovr cleared", v, stat_of(0, 0, 0, 1, 0));
    send(8'h44, 1'b1, 1'b1, 0);
    bus_read(2'd2, v); chk("R9 resumed", v, 8'h44);

    // R8 framing error with break, R10 line level
    send(8'hA5, 1'b0, 1'b0, 1);
    bus_read(2'd1, v); chk("R8 R10 break status", v, stat_of(1, 0, 1, 0, 0));
    bus_read(2'd2, v); chk("R8 byte stored", v, 8'hA5);
    @(negedge clk); rx = 1;
    repeat (8) @(negedge clk);
    bus_read(2'd1, v); chk("R10 line high", v, stat_of(0, 0, 1, 1, 0));
    send(8'h66, 1'b0, 1'b1, 0);
    bus_read(2'd1, v); chk("R9 halted frm", v, stat_of(0, 0, 1, 1, 0));
    bus_write(2'd1, 8'h04);
    send(8'h77, 1'b0, 1'b1, 0);
    bus_read(2'd1, v); chk("R9 frm cleared", v, stat_of(1, 0, 0, 1, 0));
    bus_read(2'd2, v); chk("R9 frm resumed", v, 8'h77);

    // R1 glitch start rejected
    @(negedge clk); rx = 0;
    repeat (3) @(negedge clk);
    rx = 1;
    repeat (300) @(negedge clk);
    bus_read(2'd1, v); chk("R1 glitch", v & 1, 0);

    // R11 abort by clearing enable
    @(negedge clk); rx = 0;
    repeat (40) @(negedge clk);
    bus_write(2'd0, 8'h04);
    rx = 1;
    repeat (300) @(negedge clk);
    bus_read(2'd1, v); chk("R11 nothing stored", v, stat_of(0, 0, 0, 1, 0));
    send(8'h3C, 1'b0, 1'b1, 0);
    bus_read(2'd1, v); chk("R11 disabled ignores", v & 1, 0);
    bus_write(2'd0, 8'h05);
    send(8'h5A, 1'b0, 1'b1, 0);
    bus_read(2'd2, v); chk("R11 after re-enable", v, 8'h5A);

    done_run = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule